// File: doc/BRIEF.md
# Two-Cluster Workload Balance Counter

This block keeps a single signed estimate of which of two execution clusters, called A and B, carries more work. The instruction steering stage reads this estimate to pick the less loaded cluster for new instructions. A positive value means cluster A is the heavier one. The estimate combines two inputs:

- **Dispatch term.** Decode reports, slot by slot, where each instruction in the current cycle went. Every instruction sent to A moves the estimate up by one, and every instruction sent to B moves it down by one.
- **Windowed ready term.** Each cycle the block also receives the ready-instruction count of each cluster's queue. From these it forms a ready term, which is non-zero only when one cluster has more ready work than it can issue in a cycle and the other cluster has less. The block keeps a running sum of this term over the most recent WIN cycles. When a term leaves the window, it is subtracted again.

Both terms enter one saturating register. A second output flags a large imbalance: it is raised when the magnitude of the estimate is greater than eight times the window length.

The slot inputs and the ready counts are accepted every cycle. The block has no handshake and never applies back-pressure. A slot with its valid bit low carries no instruction and has no effect.

Top module: `cluster_load_balance`

## Requirements
- R1: A synchronous reset (rst_i high at a rising edge) sets bal_o to zero and heavy_o low. It also empties the ready window, so after reset no earlier ready term is ever subtracted.
- R2: At each edge, every slot with its slot_vld_i bit set changes bal_o by one. The direction comes from the slot's slot_side_i bit: 0 selects cluster A and adds +1, 1 selects cluster B and adds -1. Slots with the valid bit clear have no effect, whatever their side bit.
- R3: The per-cycle ready term is rdy_a_i minus rdy_b_i in either of two cases: rdy_a_i > 4 and rdy_b_i < 4, or rdy_b_i > 4 and rdy_a_i < 4. In every other case, including either count being exactly 4, the term is zero.
- R4: A ready term presented in the cycle before edge k is added to bal_o at edge k. It is subtracted at edge k+WIN, where WIN defaults to 16.
- R5: At a single edge, the dispatch step, the newest ready term and the subtraction of the expiring ready term are all applied together to one update of bal_o.
- R6: bal_o saturates at +(2^(BAL_W-1)-1), which is 32767 by default, and stays there while updates keep pushing upward. It never wraps to a negative value.
- R7: bal_o saturates at -2^(BAL_W-1), which is -32768 by default, and stays there while updates keep pushing downward. It never wraps to a positive value.
- R8: heavy_o is high exactly when |bal_o| > 8*WIN (128 by default). It changes at the same edge as bal_o and is low at a magnitude of exactly 128.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| slot_vld_i | input | SLOTS (8) | Per decode slot: an instruction was steered this cycle |
| slot_side_i | input | SLOTS (8) | Per decode slot: target cluster, 0 = A, 1 = B |
| rdy_a_i | input | RDY_W (7) | Ready-instruction count of cluster A's queue |
| rdy_b_i | input | RDY_W (7) | Ready-instruction count of cluster B's queue |
| bal_o | output | BAL_W (16) | Signed balance estimate; positive means A is more loaded |
| heavy_o | output | 1 | Significant imbalance: \|bal_o\| > 8*WIN |

## Verification
The riskiest coincidence is a dispatch step and the expiry of an old ready term landing on the same edge, possibly together with a new ready term. To provoke it, the bench loads a single ready term and waits exactly WIN cycles. On the expiry edge it presents both slot steps and a fresh ready term of the opposite sign. Only the exact sum of all three contributions is accepted, so a design that drops one of them, or applies it a cycle early or late, gives a different value. Saturation is pushed in both directions, and the flag threshold is checked one unit on each side of its limit.

// File: rtl/clb_pkg.sv
`timescale 1ns/1ps
package clb_pkg;
  typedef enum logic {
    SIDE_A = 1'b0,
    SIDE_B = 1'b1
  } side_e;
endpackage

// File: rtl/clb_step_count.sv
`timescale 1ns/1ps
module clb_step_count #(
  parameter int SLOTS  = 8,
  parameter int STEP_W = $clog2(SLOTS + 1) + 1
) (
  input  logic [SLOTS-1:0]         vld_i,
  input  logic [SLOTS-1:0]         side_i,
  output logic signed [STEP_W-1:0] step_o
);
  import clb_pkg::*;
  localparam int CNT_W = STEP_W - 1;

  logic [CNT_W-1:0] n_a, n_b;

  always_comb begin
    n_a = '0;
    n_b = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (vld_i[i]) begin
        if (side_e'(side_i[i]) == SIDE_B) n_b = n_b + CNT_W'(1);
        else                              n_a = n_a + CNT_W'(1);
      end
    end
  end

  assign step_o = $signed({1'b0, n_a}) - $signed({1'b0, n_b});
endmodule

// File: rtl/clb_ready_term.sv
`timescale 1ns/1ps
module clb_ready_term #(
  parameter int RDY_W   = 7,
  parameter int ISSUE_W = 4,
  parameter int TERM_W  = RDY_W + 1
) (
  input  logic [RDY_W-1:0]         rdy_a_i,
  input  logic [RDY_W-1:0]         rdy_b_i,
  output logic signed [TERM_W-1:0] term_o
);
  localparam logic [RDY_W-1:0] IW = RDY_W'(ISSUE_W);

  logic a_over, a_under, b_over, b_under, gate;
  logic signed [TERM_W-1:0] diff;

  assign a_over  = rdy_a_i > IW;
  assign a_under = rdy_a_i < IW;
  assign b_over  = rdy_b_i > IW;
  assign b_under = rdy_b_i < IW;
  assign gate    = (a_over && b_under) || (b_over && a_under);
  assign diff    = $signed({1'b0, rdy_a_i}) - $signed({1'b0, rdy_b_i});
  assign term_o  = gate ? diff : '0;
endmodule

// File: rtl/clb_window.sv
`timescale 1ns/1ps
module clb_window #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic signed [W-1:0] new_i,
  output logic signed [W-1:0] old_o
);
  logic signed [W-1:0] stg [DEPTH];

  always_ff @(posedge clk_i) begin
    if (rst_i) stg[0] <= '0;
    else       stg[0] <= new_i;
  end

  generate
    for (genvar g = 1; g < DEPTH; g++) begin : g_stage
      always_ff @(posedge clk_i) begin
        if (rst_i) stg[g] <= '0;
        else       stg[g] <= stg[g-1];
      end
    end
  endgenerate

  assign old_o = stg[DEPTH-1];
endmodule

// File: rtl/cluster_load_balance.sv
`timescale 1ns/1ps
module cluster_load_balance #(
  parameter int SLOTS   = 8,
  parameter int RDY_W   = 7,
  parameter int ISSUE_W = 4,
  parameter int WIN     = 16,
  parameter int BAL_W   = 16,
  parameter int THR_MUL = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_i,
  input  logic [SLOTS-1:0]         slot_vld_i,
  input  logic [SLOTS-1:0]         slot_side_i,
  input  logic [RDY_W-1:0]         rdy_a_i,
  input  logic [RDY_W-1:0]         rdy_b_i,
  output logic signed [BAL_W-1:0]  bal_o,
  output logic                     heavy_o
);
  localparam int STEP_W = $clog2(SLOTS + 1) + 1;
  localparam int TERM_W = RDY_W + 1;
  localparam int SUM_W  = BAL_W + 2;
  localparam logic signed [SUM_W-1:0] SAT_HI = SUM_W'((64'sd1 <<< (BAL_W - 1)) - 64'sd1);
  localparam logic signed [SUM_W-1:0] SAT_LO = -SAT_HI - SUM_W'(1);
  localparam logic signed [SUM_W-1:0] THR_P  = SUM_W'(THR_MUL * WIN);

  logic signed [STEP_W-1:0] step_s;
  logic signed [TERM_W-1:0] term_s, old_s;
  logic signed [SUM_W-1:0]  sum_s, sat_s;
  logic signed [BAL_W-1:0]  bal_q;
  logic                     heavy_q;

  clb_step_count #(.SLOTS(SLOTS), .STEP_W(STEP_W)) u_step (
    .vld_i (slot_vld_i),
    .side_i(slot_side_i),
    .step_o(step_s)
  );

  clb_ready_term #(.RDY_W(RDY_W), .ISSUE_W(ISSUE_W), .TERM_W(TERM_W)) u_term (
    .rdy_a_i(rdy_a_i),
    .rdy_b_i(rdy_b_i),
    .term_o (term_s)
  );

  clb_window #(.DEPTH(WIN), .W(TERM_W)) u_win (
    .clk_i(clk_i),
    .rst_i(rst_i),
    .new_i(term_s),
    .old_o(old_s)
  );

  assign sum_s = SUM_W'(bal_q) + SUM_W'(step_s) + SUM_W'(term_s) - SUM_W'(old_s);

  always_comb begin
    if (sum_s > SAT_HI)      sat_s = SAT_HI;
    else if (sum_s < SAT_LO) sat_s = SAT_LO;
    else                     sat_s = sum_s;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      bal_q   <= '0;
      heavy_q <= 1'b0;
    end else begin
      bal_q   <= BAL_W'(sat_s);
      heavy_q <= (sat_s > THR_P) || (sat_s < -THR_P);
    end
  end

  assign bal_o   = bal_q;
  assign heavy_o = heavy_q;
endmodule

// File: rtl/clb_checker.sv
`timescale 1ns/1ps
module clb_checker #(
  parameter int BAL_W  = 16,
  parameter int STEP_W = 5,
  parameter int TERM_W = 8,
  parameter int THR    = 128
) (
  input logic                     clk_i,
  input logic                     rst_i,
  input logic signed [BAL_W-1:0]  bal_i,
  input logic                     heavy_i,
  input logic signed [STEP_W-1:0] step_i,
  input logic signed [TERM_W-1:0] term_i,
  input logic signed [TERM_W-1:0] old_i
);
  a_r1_reset_clears: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(rst_i) |-> (bal_i == '0) && !heavy_i);

  a_r1_window_empty: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(rst_i) |-> (old_i == '0));

  a_r5_quiet_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(!rst_i) && $past(step_i == '0) && $past(term_i == '0) && $past(old_i == '0))
    |-> $stable(bal_i));

  a_r6_no_pos_wrap: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(!rst_i) && ($past(bal_i) > 0) && $past(step_i >= 0) && $past(term_i >= old_i))
    |-> (bal_i >= $past(bal_i)));

  a_r7_no_neg_wrap: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(!rst_i) && ($past(bal_i) < 0) && $past(step_i <= 0) && $past(term_i <= old_i))
    |-> (bal_i <= $past(bal_i)));

  a_r8_flag_match: assert property (@(posedge clk_i) disable iff (rst_i)
    heavy_i == ((int'(bal_i) > THR) || (int'(bal_i) < -THR)));
endmodule

bind cluster_load_balance clb_checker #(
  .BAL_W (BAL_W),
  .STEP_W(STEP_W),
  .TERM_W(TERM_W),
  .THR   (THR_MUL * WIN)
) u_chk (
  .clk_i  (clk_i),
  .rst_i  (rst_i),
  .bal_i  (bal_o),
  .heavy_i(heavy_o),
  .step_i (step_s),
  .term_i (term_s),
  .old_i  (old_s)
);

// File: tb/cluster_load_balance_test.sv
`timescale 1ns/1ps
module cluster_load_balance_test;
  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [7:0]        vld = '0;
  logic [7:0]        side = '0;
  logic [6:0]        ra = '0;
  logic [6:0]        rb = '0;
  logic signed [15:0] bal;
  logic              heavy;
  int total = 0;
  int bad   = 0;

  cluster_load_balance uut (
    .clk_i(clk), .rst_i(rst), .slot_vld_i(vld), .slot_side_i(side),
    .rdy_a_i(ra), .rdy_b_i(rb), .bal_o(bal), .heavy_o(heavy)
  );

  always #2.5 clk = ~clk;

  // {valid, side, rdy_a, rdy_b, expected balance}, flag expected low throughout
  localparam logic [45:0] VEC [8] = '{
    {8'h0F, 8'h00, 7'd0,  7'd0,  16'd4},     // R2 four slots to A
    {8'hFF, 8'hF0, 7'd6,  7'd2,  16'd8},     // R2 cancel, R3 term +4
    {8'h03, 8'h03, 7'd4,  7'd10, 16'd6},     // R2 two to B, R3 count at 4 gives 0
    {8'h00, 8'hFF, 7'd1,  7'd9,  16'hFFFE},  // R2 invalid ignored, R3 term -8
    {8'h80, 8'h80, 7'd5,  7'd4,  16'hFFFD},  // R3 other side at 4 gives 0
    {8'hAA, 8'h00, 7'd20, 7'd0,  16'd21},    // R2 +4, R3 +20
    {8'h00, 8'h00, 7'd3,  7'd3,  16'd21},    // R3 both under gives 0
    {8'h0F, 8'h05, 7'd0,  7'd64, 16'hFFD5}   // R2 mixed, R3 -64
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input logic [7:0] v, input logic [7:0] s,
                       input logic [6:0] a, input logic [6:0] b);
    vld = v; side = s; ra = a; rb = b;
  endtask

  task automatic do_reset();
    drive(8'h00, 8'h00, 7'd0, 7'd0);
    rst = 1'b1;
    tick();
    tick();
    rst = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    check("R1 reset balance", int'(bal), 0);
    check("R1 reset flag", int'(heavy), 0);

    for (int i = 0; i < 8; i++) begin
      drive(VEC[i][45:38], VEC[i][37:30], VEC[i][29:23], VEC[i][22:16]);
      tick();
      check($sformatf("R2/R3 table row %0d balance", i), int'(bal), int'($signed(VEC[i][15:0])));
      check($sformatf("R8 table row %0d flag", i), int'(heavy), 0);
    end

    // R4 term leaves after exactly WIN edges
    do_reset();
    drive(8'h00, 8'h00, 7'd10, 7'd0);
    tick();
    check("R4 term entered", int'(bal), 10);
    drive(8'h00, 8'h00, 7'd0, 7'd0);
    repeat (15) tick();
    check("R4 term still in window", int'(bal), 10);
    tick();
    check("R4 term expired", int'(bal), 0);

    // R5 dispatch, new term and expiry on one edge
    do_reset();
    drive(8'h00, 8'h00, 7'd10, 7'd0);
    tick();
    drive(8'h00, 8'h00, 7'd0, 7'd0);
    repeat (15) tick();
    drive(8'h07, 8'h00, 7'd0, 7'd7);
    tick();
    check("R5 combined update", int'(bal), -4);

    // R1 reset empties window
    do_reset();
    drive(8'h00, 8'h00, 7'd20, 7'd0);
    repeat (3) tick();
    check("R1 preload", int'(bal), 60);
    do_reset();
    repeat (20) tick();
    check("R1 no stale subtraction", int'(bal), 0);
    check("R1 flag after reset", int'(heavy), 0);

    // R8 positive threshold boundary
    do_reset();
    drive(8'h00, 8'h00, 7'd64, 7'd0);
    repeat (2) tick();
    check("R8 at +128 balance", int'(bal), 128);
    check("R8 at +128 flag low", int'(heavy), 0);
    drive(8'h01, 8'h00, 7'd0, 7'd0);
    tick();
    check("R8 at +129 balance", int'(bal), 129);
    check("R8 at +129 flag high", int'(heavy), 1);

    // R8 negative threshold boundary
    do_reset();
    drive(8'h00, 8'h00, 7'd0, 7'd64);
    repeat (2) tick();
    check("R8 at -128 balance", int'(bal), -128);
    check("R8 at -128 flag low", int'(heavy), 0);
    drive(8'h01, 8'h01, 7'd0, 7'd0);
    tick();
    check("R8 at -129 balance", int'(bal), -129);
    check("R8 at -129 flag high", int'(heavy), 1);

    // R6 upper saturation
    do_reset();
    drive(8'hFF, 8'h00, 7'd0, 7'd0);
    repeat (4200) tick();
    check("R6 saturated high", int'(bal), 32767);
    tick();
    check("R6 holds high", int'(bal), 32767);
    check("R6 flag at limit", int'(heavy), 1);

    // R7 lower saturation
    drive(8'hFF, 8'hFF, 7'd0, 7'd0);
    repeat (8300) tick();
    check("R7 saturated low", int'(bal), -32768);
    tick();
    check("R7 holds low", int'(bal), -32768);
    check("R7 flag at limit", int'(heavy), 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule